// File: doc/BRIEF.md
# Bit-Serial Block EEPROM Engine

This block behaves as a small serial EEPROM that a host reaches one bit per bus access. Each write strobe delivers one serial input bit. Each read strobe returns one serial output bit, which is valid for as long as the strobe is held. The host first shifts in a request: a two-bit opcode, a six-bit block number and a stop bit. The engine then either takes in a 64-bit block and stores it, or sends a stored block back, one bit per read strobe.

The storage is 64 blocks of eight bytes, 512 bytes in total. Each block is held as one 64-bit word, so the first byte sent goes to the lowest byte address of the block. When no block transfer is under way, the output bit shows whether the last write has finished. A reset-if-idle pulse lets a host bring the engine back to its request state before a new transfer. This pulse is refused while a block is being sent out.

Top module: `serial_eeprom_engine`

## Requirements
- R1: The first two bits of a request form the opcode. Bits 1 then 1 select a read and bits 1 then 0 select a write. Opcodes 00 and 01 are dropped, and the engine keeps waiting for a request.
- R2: After the opcode, six bits give the block number, most significant bit first. Each block number names its own eight-byte block at byte address number×8. Writing one block leaves every other block unchanged.
- R3: In a write, 64 data bits follow the block number, then one stop bit of any value. A later read of that block returns the same 64 bits in the same order. The first bit sent is the most significant bit of the byte at the lowest address.
- R4: In a read, one stop bit of any value follows the block number. The next four read strobes return 0. The 64 read strobes after those return the block, most significant bit first.
- R5: After the 64th data bit of a read, the engine is back in its request state and accepts a new request.
- R6: The ready flag goes to 0 when the block number of a write has been received. It goes to 1 when that write's stop bit is received. Outside the dummy and data output phases, a read strobe returns the ready flag and does not move the engine.
- R7: After reset the ready flag is 0, `idle` is 1, and every block reads back as all zeros.
- R8: A pulse on `abort_idle` returns the engine to its request state and drops any partly received request. This applies only outside the dummy and data output phases. During those phases the pulse has no effect and the output stream goes on unbroken. The pulse takes priority over a write strobe in the same cycle.
- R9: Write strobes during the dummy or data output phases are ignored.
- R10: `idle` is 1 exactly when the engine is waiting for, or is partway through, a request opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe; delivers one serial input bit |
| wr_bit | input | 1 | Serial input bit carried by `wr_stb` |
| rd_stb | input | 1 | Read strobe; takes one serial output bit |
| rd_bit | output | 1 | Serial output bit, valid while `rd_stb` is high |
| abort_idle | input | 1 | Reset-if-idle pulse |
| idle | output | 1 | High while the engine waits for a request |

## Verification
A strobe held high across one rising edge moves the engine at that edge. So `idle` and the next output bit are due in the cycle after that edge. The bench samples them at the following falling edge. `rd_bit` depends combinationally on state that is already registered. The bench reads it 1 ns after it raises `rd_stb` on a falling edge, before the edge that consumes the bit. Every block is written and read back in a full sweep. The expected words come from an arithmetic pattern of the block number. Opcode misuse, aborts inside and outside the output phase, and the ready timing are each checked at the first cycle the result can appear.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_CODE,
    ST_ADDR,
    ST_DATA_IN,
    ST_STOP_W,
    ST_STOP_R,
    ST_DUMMY,
    ST_TX
  } eep_state_e;
endpackage

// File: rtl/eep_block_ram.sv
// One word per block; write-first not required, read is registered.
module eep_block_ram #(
  parameter int ADDR_BITS = 6,
  parameter int WIDTH     = 64
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [ADDR_BITS-1:0] waddr,
  input  logic [WIDTH-1:0]     wdata,
  input  logic [ADDR_BITS-1:0] raddr,
  output logic [WIDTH-1:0]     q
);
  localparam int DEPTH = 1 << ADDR_BITS;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/eep_fill_map.sv
// One flag per block, cleared by reset, so the array itself needs no reset.
module eep_fill_map #(
  parameter int ADDR_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [ADDR_BITS-1:0] waddr,
  input  logic [ADDR_BITS-1:0] raddr,
  output logic                 hit
);
  localparam int DEPTH = 1 << ADDR_BITS;

  logic [DEPTH-1:0] filled;

  always_ff @(posedge clk) begin
    if (rst) begin
      filled <= '0;
      hit    <= 1'b0;
    end else begin
      if (we) filled[waddr] <= 1'b1;
      hit <= filled[raddr];
    end
  end
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_BITS  = 6,
  parameter int BLOCK_BITS = 64,
  parameter int DUMMY_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_stb,
  input  logic                  wr_bit,
  input  logic                  rd_stb,
  input  logic                  abort_idle,
  input  logic [BLOCK_BITS-1:0] blk_data,
  output logic                  rd_bit,
  output logic                  idle,
  output logic                  mem_we,
  output logic [BLOCK_BITS-1:0] mem_wdata,
  output logic [ADDR_BITS-1:0]  blk_addr,
  output eep_state_e            state
);
  localparam int CW = $clog2(BLOCK_BITS + 1);
  localparam logic [CW-1:0] LAST_CODE  = CW'(1);
  localparam logic [CW-1:0] LAST_ADDR  = CW'(ADDR_BITS - 1);
  localparam logic [CW-1:0] LAST_DATA  = CW'(BLOCK_BITS - 1);
  localparam logic [CW-1:0] LAST_DUMMY = CW'(DUMMY_BITS - 1);

  logic [CW-1:0]         cnt;
  logic [BLOCK_BITS-1:0] rx_sr;
  logic [BLOCK_BITS-1:0] tx_sr;
  logic [BLOCK_BITS-1:0] rx_next;
  logic                  op_rd;
  logic                  ready;
  logic                  tx_phase;

  always_comb begin
    tx_phase  = (state == ST_DUMMY) || (state == ST_TX);
    rx_next   = {rx_sr[BLOCK_BITS-2:0], wr_bit};
    idle      = (state == ST_CODE);
    mem_wdata = rx_next;
    mem_we    = wr_stb && !abort_idle && (state == ST_DATA_IN) && (cnt == LAST_DATA);
    if (state == ST_TX)         rd_bit = tx_sr[BLOCK_BITS-1];
    else if (state == ST_DUMMY) rd_bit = 1'b0;
    else                        rd_bit = ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_CODE;
      cnt      <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      op_rd    <= 1'b0;
      ready    <= 1'b0;
      blk_addr <= '0;
    end else if (abort_idle && !tx_phase) begin
      state <= ST_CODE;
      cnt   <= '0;
      rx_sr <= '0;
      tx_sr <= '0;
    end else if (wr_stb && !tx_phase) begin
      case (state)
        ST_CODE: begin
          if (cnt == LAST_CODE) begin
            cnt   <= '0;
            rx_sr <= '0;
            if (rx_sr[0]) begin
              op_rd <= wr_bit;
              state <= ST_ADDR;
            end
          end else begin
            cnt   <= cnt + 1'b1;
            rx_sr <= rx_next;
          end
        end
        ST_ADDR: begin
          if (cnt == LAST_ADDR) begin
            blk_addr <= rx_next[ADDR_BITS-1:0];
            cnt      <= '0;
            rx_sr    <= '0;
            if (op_rd) begin
              state <= ST_STOP_R;
            end else begin
              ready <= 1'b0;
              state <= ST_DATA_IN;
            end
          end else begin
            cnt   <= cnt + 1'b1;
            rx_sr <= rx_next;
          end
        end
        ST_DATA_IN: begin
          if (cnt == LAST_DATA) begin
            state <= ST_STOP_W;
            cnt   <= '0;
            rx_sr <= '0;
          end else begin
            cnt   <= cnt + 1'b1;
            rx_sr <= rx_next;
          end
        end
        ST_STOP_W: begin
          ready <= 1'b1;
          state <= ST_CODE;
        end
        ST_STOP_R: begin
          state <= ST_DUMMY;
          cnt   <= '0;
        end
        default: state <= ST_CODE;
      endcase
    end else if (rd_stb && tx_phase) begin
      if (state == ST_DUMMY) begin
        tx_sr <= blk_data;
        if (cnt == LAST_DUMMY) begin
          state <= ST_TX;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        tx_sr <= {tx_sr[BLOCK_BITS-2:0], 1'b0};
        if (cnt == LAST_DATA) begin
          state <= ST_CODE;
          cnt   <= '0;
          rx_sr <= '0;
          tx_sr <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serial_eeprom_engine.sv
module serial_eeprom_engine #(
  parameter int ADDR_BITS  = 6,
  parameter int BLOCK_BITS = 64,
  parameter int DUMMY_BITS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_stb,
  input  logic wr_bit,
  input  logic rd_stb,
  output logic rd_bit,
  input  logic abort_idle,
  output logic idle
);
  import eep_pkg::*;

  logic                  mem_we;
  logic [BLOCK_BITS-1:0] mem_wdata;
  logic [BLOCK_BITS-1:0] ram_q;
  logic [BLOCK_BITS-1:0] blk_data;
  logic [ADDR_BITS-1:0]  blk_addr;
  logic                  blk_hit;
  eep_state_e            state_w;

  assign blk_data = blk_hit ? ram_q : '0;

  eep_ctrl #(
    .ADDR_BITS (ADDR_BITS),
    .BLOCK_BITS(BLOCK_BITS),
    .DUMMY_BITS(DUMMY_BITS)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .wr_bit    (wr_bit),
    .rd_stb    (rd_stb),
    .abort_idle(abort_idle),
    .blk_data  (blk_data),
    .rd_bit    (rd_bit),
    .idle      (idle),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .blk_addr  (blk_addr),
    .state     (state_w)
  );

  eep_block_ram #(
    .ADDR_BITS(ADDR_BITS),
    .WIDTH    (BLOCK_BITS)
  ) u_ram (
    .clk  (clk),
    .we   (mem_we),
    .waddr(blk_addr),
    .wdata(mem_wdata),
    .raddr(blk_addr),
    .q    (ram_q)
  );

  eep_fill_map #(
    .ADDR_BITS(ADDR_BITS)
  ) u_fill (
    .clk  (clk),
    .rst  (rst),
    .we   (mem_we),
    .waddr(blk_addr),
    .raddr(blk_addr),
    .hit  (blk_hit)
  );
endmodule

// File: rtl/eep_checker.sv
module eep_checker
  import eep_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       wr_stb,
  input logic       rd_stb,
  input logic       abort_idle,
  input logic       rd_bit,
  input logic       idle,
  input eep_state_e st
);
  // R7: first cycle out of reset is idle with ready clear
  assert_reset_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (idle && !rd_bit));

  // R8: abort outside output phases returns to request state
  assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
    (abort_idle && st != ST_DUMMY && st != ST_TX) |=> (st == ST_CODE));

  // R8: abort during data output is refused
  assert_abort_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (abort_idle && !rd_stb && st == ST_TX) |=> (st == ST_TX));

  // R6: write stop bit sets ready, visible on the idle output bit
  assert_stopw_ready_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !abort_idle && st == ST_STOP_W) |=> (idle && rd_bit));

  // R4: read stop bit enters the dummy phase, which outputs 0
  assert_stopr_dummy_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !abort_idle && st == ST_STOP_R) |=> (st == ST_DUMMY && !rd_bit));

  // R6: read strobe in a receive phase does not move the engine
  assert_rx_ignores_rd_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !wr_stb && !abort_idle && st != ST_DUMMY && st != ST_TX) |=> $stable(st));

  // R9: write strobe during output phases does not disturb them
  assert_tx_ignores_wr_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !rd_stb && st == ST_DUMMY) |=> (st == ST_DUMMY));

  // R5: data output either continues or lands in request state
  assert_tx_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && st == ST_TX) |=> (st == ST_TX || idle));
endmodule

bind serial_eeprom_engine eep_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_stb    (wr_stb),
  .rd_stb    (rd_stb),
  .abort_idle(abort_idle),
  .rd_bit    (rd_bit),
  .idle      (idle),
  .st        (state_w)
);

// File: tb/test_serial_eeprom_engine.sv
`timescale 1ns/1ps
module test_serial_eeprom_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_stb = 1'b0;
  logic wr_bit = 1'b0;
  logic rd_stb = 1'b0;
  logic abort_idle = 1'b0;
  logic rd_bit;
  logic idle;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_eeprom_engine i_serial_eeprom_engine (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .wr_bit    (wr_bit),
    .rd_stb    (rd_stb),
    .rd_bit    (rd_bit),
    .abort_idle(abort_idle),
    .idle      (idle)
  );

  function automatic logic [63:0] pat(input int a);
    return 64'h0123_4567_89AB_CDEF ^ (64'(a) * 64'h9E37_79B9_7F4A_7C15);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wbit(input logic b);
    @(negedge clk);
    wr_stb = 1'b1;
    wr_bit = b;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic rbit(output logic b);
    @(negedge clk);
    rd_stb = 1'b1;
    #1 b = rd_bit;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic pulse_abort();
    @(negedge clk);
    abort_idle = 1'b1;
    @(negedge clk);
    abort_idle = 1'b0;
  endtask

  task automatic send_req(input logic rd, input logic [5:0] a);
    wbit(1'b1);
    wbit(rd);
    for (int i = 5; i >= 0; i--) wbit(a[i]);
  endtask

  task automatic write_block(input logic [5:0] a, input logic [63:0] d);
    send_req(1'b0, a);
    for (int i = 63; i >= 0; i--) wbit(d[i]);
    wbit(1'b0);
  endtask

  task automatic read_block(input logic [5:0] a, output logic [63:0] d, output logic [3:0] dum);
    logic b;
    send_req(1'b1, a);
    wbit(1'b1);
    for (int i = 3; i >= 0; i--) begin rbit(b); dum[i] = b; end
    for (int i = 63; i >= 0; i--) begin rbit(b); d[i] = b; end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [3:0]  dum;
    logic        b;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R7 R10: reset state
    chk(idle === 1'b1, "R7 idle after reset", 64'(idle), 64'd1);
    chk(rd_bit === 1'b0, "R7 ready after reset", 64'(rd_bit), 64'd0);
    read_block(6'd5, d, dum);
    chk(d === 64'd0, "R7 blank block 5", d, 64'd0);
    chk(dum === 4'd0, "R4 dummy bits", 64'(dum), 64'd0);
    read_block(6'd63, d, dum);
    chk(d === 64'd0, "R7 blank block 63", d, 64'd0);
    @(negedge clk);
    chk(idle === 1'b1, "R5 idle after read", 64'(idle), 64'd1);

    // R1: bad opcodes dropped
    wbit(1'b0); wbit(1'b1);
    @(negedge clk);
    chk(idle === 1'b1, "R1 opcode 01 dropped", 64'(idle), 64'd1);
    wbit(1'b0); wbit(1'b0);
    @(negedge clk);
    chk(idle === 1'b1, "R1 opcode 00 dropped", 64'(idle), 64'd1);
    wbit(1'b1);
    @(negedge clk);
    chk(idle === 1'b1, "R10 idle mid opcode", 64'(idle), 64'd1);
    wbit(1'b0);
    @(negedge clk);
    chk(idle === 1'b0, "R10 leaves idle after opcode 10", 64'(idle), 64'd0);
    wbit(1'b1); wbit(1'b0);
    // R8: abort mid-address
    pulse_abort();
    @(negedge clk);
    chk(idle === 1'b1, "R8 abort mid address", 64'(idle), 64'd1);

    // R6: ready timing around a write
    send_req(1'b0, 6'd7);
    rbit(b);
    chk(b === 1'b0, "R6 ready cleared after write address", 64'(b), 64'd0);
    chk(idle === 1'b0, "R6 read strobe does not move engine", 64'(idle), 64'd0);
    for (int i = 63; i >= 0; i--) wbit(pat(100)[i]);
    rbit(b);
    chk(b === 1'b0, "R6 ready still clear before stop bit", 64'(b), 64'd0);
    wbit(1'b1);
    rbit(b);
    chk(b === 1'b1, "R6 ready set after stop bit", 64'(b), 64'd1);
    read_block(6'd7, d, dum);
    chk(d === pat(100), "R3 read back block 7", d, pat(100));

    // R2 R3 R4: full sweep
    for (int a = 0; a < 64; a++) write_block(6'(a), pat(a));
    for (int a = 0; a < 64; a++) begin
      read_block(6'(a), d, dum);
      chk(d === pat(a), "R2 R3 sweep block data", d, pat(a));
      chk(dum === 4'd0, "R4 sweep dummy bits", 64'(dum), 64'd0);
    end

    // R8 R9: abort and write strobes ignored during output
    send_req(1'b1, 6'd10);
    wbit(1'b0);
    rbit(b);
    wbit(1'b1);
    rbit(b); rbit(b); rbit(b);
    for (int i = 63; i >= 54; i--) begin rbit(b); d[i] = b; end
    pulse_abort();
    wbit(1'b1);
    @(negedge clk);
    chk(idle === 1'b0, "R8 abort refused in output", 64'(idle), 64'd0);
    for (int i = 53; i >= 0; i--) begin rbit(b); d[i] = b; end
    chk(d === pat(10), "R9 output unbroken", d, pat(10));
    @(negedge clk);
    chk(idle === 1'b1, "R5 back to request state", 64'(idle), 64'd1);
    read_block(6'd11, d, dum);
    chk(d === pat(11), "R5 next request accepted", d, pat(11));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule